// File: doc/BRIEF.md
# Serial Frame Receiver with Receive Queue and Interrupt Requests

This block receives asynchronous serial frames from one line that idles high. It watches for a low start bit and times every later sample from that edge. Each sample is taken at the centre of its bit cell, using a 16x oversampling tick supplied from outside the block. Data arrives least significant bit first. The frame may have 8 or 7 data bits, an optional odd or even parity bit, and one or two stop bits. When the frame ends, the block checks it. A good byte, with its parity-error bit, goes into a 16-entry receive queue. Software or a DMA engine drains the queue through a show-ahead read port.

Four status conditions are kept: queue at trigger level, data waiting while the line is idle, receive error, and line break. Each has its own enable. The two data conditions drive request line A, and the two fault conditions drive request line B. A bad stop bit or a parity fault never stops reception; the next frame is taken as usual. Once a break is seen, no further bytes enter the queue until software clears the break.

Top module: `serial_rx_irq`

## Requirements
- R1: A frame starts when the synchronised line is low on a tick while idle. If the line is high again 8 ticks later (mid start bit), the frame is abandoned as a glitch, nothing is stored, and the receiver returns to idle.
- R2: Data bits are taken at mid-bit, least significant bit first. With `cfgSevenBits`=1, seven bits are received and bit 7 of the stored byte reads 0.
- R3: With `cfgParityOn`=1, one parity bit follows the data. With `cfgParityOdd`=0, the data bits plus the parity bit must hold an even number of ones; with 1, an odd number. A mismatch still stores the byte, with `popParErr`=1 for that entry.
- R4: A frame whose stop bit samples 0, and which is not all zeros, is discarded. It sets a sticky framing fault that `clrErr` clears. The next frame is received normally.
- R5: With `cfgTwoStop`=1, only the first stop bit is checked, so a 0 in the second stop bit has no effect on the frame.
- R6: A frame that is all zeros (data, parity if enabled, and stop) sets `flagBreak` and is not stored. While `flagBreak` is 1, no frame is stored. `clrBreak` clears the flag.
- R7: The queue holds 16 entries, and `fifoCount` never exceeds 16. A good frame that arrives when the queue is full is dropped, and the queued data is unchanged.
- R8: `flagFull` is 1 exactly when `fifoCount` is at least the trigger level. `trigSel` encodes the level: 0→1, 1→4, 2→8, 3→14.
- R9: `flagReady` is 1 when `fifoCount` is nonzero and below the trigger level, and the receiver has spent at least 240 ticks (15 bit times) idle since the last start was detected.
- R10: `irqA` = (`flagFull` and `enFull`) or (`flagReady` and `enReady`). `irqB` = (`flagError` and `enError`) or (`flagBreak` and `enBreak`).
- R11: `flagError` is 1 while the sticky framing fault is set, or while the queue is non-empty and its head entry has a parity error.
- R12: After reset, the queue is empty and all flags and requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial data line, idle high |
| tick16 | input | 1 | Oversampling tick, 16 per bit time |
| cfgSevenBits | input | 1 | 1: seven data bits, 0: eight |
| cfgParityOn | input | 1 | Parity bit present |
| cfgParityOdd | input | 1 | 1: odd parity, 0: even parity |
| cfgTwoStop | input | 1 | Two stop bits (only the first is checked) |
| trigSel | input | 2 | Trigger level select (1, 4, 8, 14) |
| enFull | input | 1 | Enable for trigger-level request |
| enReady | input | 1 | Enable for idle data-ready request |
| enError | input | 1 | Enable for receive-error request |
| enBreak | input | 1 | Enable for break request |
| clrErr | input | 1 | Clears the sticky framing fault |
| clrBreak | input | 1 | Clears the break flag |
| popEn | input | 1 | Removes the head entry (ignored when empty) |
| popData | output | 8 | Head entry data byte |
| popParErr | output | 1 | Head entry parity-error bit |
| fifoCount | output | 5 | Number of queued entries |
| flagFull | output | 1 | Queue at or above trigger level |
| flagReady | output | 1 | Data waiting below trigger with idle line |
| flagError | output | 1 | Framing fault or head parity error |
| flagBreak | output | 1 | Break seen |
| irqA | output | 1 | Data request line |
| irqB | output | 1 | Fault request line |

## Verification
On every cycle, the assertions check that the queue count stays in range and moves by at most one entry per cycle. They also check that the count never rises while a break is latched, that the full and ready flags never coincide, and that each request line stays low when both of its enables are off. Several behaviours can only be shown by the bench's frames: correct bit order, the parity polarity, glitch rejection, the second stop bit being ignored, and a frame being dropped after a framing fault. The same holds for the trigger encoding and the 15-bit idle delay before data-ready.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
  } rxState_t;

  // strobes from bit-timing control to the datapath
  typedef struct packed {
    logic frameStart;  // start edge seen while idle
    logic shiftBit;    // mid-bit sample of a data bit
    logic parBit;      // mid-bit sample of parity
    logic stopBit;     // mid-bit sample of first stop bit
    logic idleTick;    // tick spent idle with line high
    logic lineVal;     // synchronised line value
  } rxStrobe_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DW = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      rxLine,
  input  logic      cfgSevenBits,
  input  logic      cfgParityOn,
  input  logic      cfgTwoStop,
  output rxStrobe_t strb
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] MIDCNT  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] LASTCNT = CW'(OVERSAMPLE - 1);

  rxState_t state;
  logic [CW-1:0] tickCnt;
  logic [BW-1:0] bitIdx;
  logic rxMeta, rxS;
  logic atEnd;
  logic [BW-1:0] lastIdx;

  assign atEnd   = tick && (tickCnt == LASTCNT);
  assign lastIdx = cfgSevenBits ? BW'(DW - 2) : BW'(DW - 1);

  always_comb begin
    strb = '0;
    strb.lineVal = rxS;
    case (state)
      S_IDLE: begin
        strb.frameStart = tick && !rxS;
        strb.idleTick   = tick && rxS;
      end
      S_DATA:  strb.shiftBit = atEnd;
      S_PAR:   strb.parBit   = atEnd;
      S_STOP1: strb.stopBit  = atEnd;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      rxMeta  <= 1'b1;
      rxS     <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxS    <= rxMeta;
      if (tick) begin
        case (state)
          S_IDLE: if (!rxS) begin
            state   <= S_START;
            tickCnt <= '0;
          end
          S_START: begin
            if (tickCnt == MIDCNT) begin
              tickCnt <= '0;
              bitIdx  <= '0;
              state   <= rxS ? S_IDLE : S_DATA;
            end else tickCnt <= tickCnt + 1'b1;
          end
          default: begin
            if (tickCnt == LASTCNT) begin
              tickCnt <= '0;
              case (state)
                S_DATA: begin
                  if (bitIdx == lastIdx) state <= cfgParityOn ? S_PAR : S_STOP1;
                  else bitIdx <= bitIdx + 1'b1;
                end
                S_PAR:   state <= S_STOP1;
                S_STOP1: state <= cfgTwoStop ? S_STOP2 : S_IDLE;
                default: state <= S_IDLE;
              endcase
            end else tickCnt <= tickCnt + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_data.sv
module serial_rx_data
  import serial_rx_pkg::*;
#(
  parameter int DW = 8,
  parameter int DEPTH = 16,
  parameter int OVERSAMPLE = 16,
  parameter int IDLE_BITS = 15
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rxStrobe_t                  strb,
  input  logic                       cfgSevenBits,
  input  logic                       cfgParityOn,
  input  logic                       cfgParityOdd,
  input  logic [1:0]                 trigSel,
  input  logic                       popEn,
  input  logic                       clrErr,
  input  logic                       clrBreak,
  output logic [DW-1:0]              popData,
  output logic                       popParErr,
  output logic [$clog2(DEPTH):0]     fifoCount,
  output logic                       flagFull,
  output logic                       flagReady,
  output logic                       flagError,
  output logic                       flagBreak
);
  localparam int AW = $clog2(DEPTH);
  localparam int CNTW = AW + 1;
  localparam int IDLE_TICKS = IDLE_BITS * OVERSAMPLE;
  localparam int IW = $clog2(IDLE_TICKS + 1);

  logic [DW-1:0] shiftReg;
  logic parReg;
  logic frmSticky;
  logic [IW-1:0] idleCnt;
  logic [DW:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [DW-1:0] dataByte;
  logic parErr, allZero, push, pop, qFull, qEmpty;
  logic [CNTW-1:0] trigLevel;

  assign dataByte = cfgSevenBits ? {1'b0, shiftReg[DW-1:1]} : shiftReg;
  assign parErr   = cfgParityOn && ((^dataByte) ^ parReg ^ cfgParityOdd);
  assign allZero  = (dataByte == '0) && !parReg && !strb.lineVal;
  assign qFull    = (fifoCount == CNTW'(DEPTH));
  assign qEmpty   = (fifoCount == '0);
  assign push     = strb.stopBit && strb.lineVal && !flagBreak && !qFull;
  assign pop      = popEn && !qEmpty;

  always_comb begin
    case (trigSel)
      2'd0:    trigLevel = CNTW'(1);
      2'd1:    trigLevel = CNTW'(4);
      2'd2:    trigLevel = CNTW'(8);
      default: trigLevel = CNTW'(14);
    endcase
  end

  assign popData   = mem[rdPtr][DW-1:0];
  assign popParErr = mem[rdPtr][DW];
  assign flagFull  = fifoCount >= trigLevel;
  assign flagReady = !qEmpty && (fifoCount < trigLevel) && (idleCnt == IW'(IDLE_TICKS));
  assign flagError = frmSticky || (!qEmpty && mem[rdPtr][DW]);

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= {parErr, dataByte};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parReg    <= 1'b0;
      frmSticky <= 1'b0;
      flagBreak <= 1'b0;
      idleCnt   <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (strb.shiftBit) shiftReg <= {strb.lineVal, shiftReg[DW-1:1]};
      if (strb.frameStart) parReg <= 1'b0;
      else if (strb.parBit) parReg <= strb.lineVal;

      if (strb.stopBit && allZero) flagBreak <= 1'b1;
      else if (clrBreak) flagBreak <= 1'b0;

      if (strb.stopBit && !strb.lineVal && !allZero) frmSticky <= 1'b1;
      else if (clrErr) frmSticky <= 1'b0;

      if (strb.frameStart) idleCnt <= '0;
      else if (strb.idleTick && idleCnt != IW'(IDLE_TICKS)) idleCnt <= idleCnt + 1'b1;

      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   fifoCount <= fifoCount + 1'b1;
        2'b01:   fifoCount <= fifoCount - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_irq.sv
module serial_rx_irq
  import serial_rx_pkg::*;
#(
  parameter int DW = 8,
  parameter int DEPTH = 16,
  parameter int OVERSAMPLE = 16,
  parameter int IDLE_BITS = 15
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rxLine,
  input  logic                   tick16,
  input  logic                   cfgSevenBits,
  input  logic                   cfgParityOn,
  input  logic                   cfgParityOdd,
  input  logic                   cfgTwoStop,
  input  logic [1:0]             trigSel,
  input  logic                   enFull,
  input  logic                   enReady,
  input  logic                   enError,
  input  logic                   enBreak,
  input  logic                   clrErr,
  input  logic                   clrBreak,
  input  logic                   popEn,
  output logic [DW-1:0]          popData,
  output logic                   popParErr,
  output logic [$clog2(DEPTH):0] fifoCount,
  output logic                   flagFull,
  output logic                   flagReady,
  output logic                   flagError,
  output logic                   flagBreak,
  output logic                   irqA,
  output logic                   irqB
);
  rxStrobe_t strb;

  serial_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick16), .rxLine(rxLine),
    .cfgSevenBits(cfgSevenBits), .cfgParityOn(cfgParityOn),
    .cfgTwoStop(cfgTwoStop), .strb(strb)
  );

  serial_rx_data #(.DW(DW), .DEPTH(DEPTH), .OVERSAMPLE(OVERSAMPLE),
                   .IDLE_BITS(IDLE_BITS)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgSevenBits(cfgSevenBits), .cfgParityOn(cfgParityOn),
    .cfgParityOdd(cfgParityOdd), .trigSel(trigSel), .popEn(popEn),
    .clrErr(clrErr), .clrBreak(clrBreak), .popData(popData),
    .popParErr(popParErr), .fifoCount(fifoCount), .flagFull(flagFull),
    .flagReady(flagReady), .flagError(flagError), .flagBreak(flagBreak)
  );

  assign irqA = (flagFull && enFull) || (flagReady && enReady);
  assign irqB = (flagError && enError) || (flagBreak && enBreak);
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [$clog2(DEPTH):0] fifoCount,
  input logic                   flagFull,
  input logic                   flagReady,
  input logic                   flagBreak,
  input logic                   enFull,
  input logic                   enReady,
  input logic                   enError,
  input logic                   enBreak,
  input logic                   irqA,
  input logic                   irqB
);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    int'(fifoCount) <= DEPTH);

  assert_single_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (int'(fifoCount) <= int'($past(fifoCount)) + 1) &&
             (int'(fifoCount) + 1 >= int'($past(fifoCount))));

  assert_break_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    flagBreak |=> int'(fifoCount) <= int'($past(fifoCount)));

  assert_full_ready_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(flagFull && flagReady));

  assert_empty_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == '0) |-> (!flagFull && !flagReady));

  assert_top_trig_R8: assert property (@(posedge clk) disable iff (!rstN)
    (int'(fifoCount) >= 14) |-> flagFull);

  assert_irqa_masked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!enFull && !enReady) |-> !irqA);

  assert_irqb_masked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!enError && !enBreak) |-> !irqB);
endmodule

bind serial_rx_irq serial_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .flagFull(flagFull),
  .flagReady(flagReady), .flagBreak(flagBreak), .enFull(enFull),
  .enReady(enReady), .enError(enError), .enBreak(enBreak),
  .irqA(irqA), .irqB(irqB)
);

// File: tb/serial_rx_irq_tb.sv
module serial_rx_irq_tb;
  logic clk = 1'b0, rstN = 1'b0, rxLine = 1'b1, tick16 = 1'b0;
  logic cfgSevenBits = 0, cfgParityOn = 0, cfgParityOdd = 0, cfgTwoStop = 0;
  logic [1:0] trigSel = 2'd3;
  logic enFull = 0, enReady = 0, enError = 0, enBreak = 0;
  logic clrErr = 0, clrBreak = 0, popEn = 0;
  logic [7:0] popData;
  logic popParErr, flagFull, flagReady, flagError, flagBreak, irqA, irqB;
  logic [4:0] fifoCount;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam int BITCLK = 32;  // 16 ticks, one every 2 clocks

  // {data, seven, parOn, parOdd, flipPar, expData, expPe}
  localparam logic [20:0] VEC [6] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0},
    {8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b0},
    {8'h81, 1'b0, 1'b1, 1'b1, 1'b0, 8'h81, 1'b0},
    {8'hF0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hF0, 1'b1},
    {8'hD5, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0},
    {8'h5A, 1'b1, 1'b1, 1'b1, 1'b1, 8'h5A, 1'b1}
  };

  serial_rx_irq u_dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .tick16(tick16),
    .cfgSevenBits(cfgSevenBits), .cfgParityOn(cfgParityOn),
    .cfgParityOdd(cfgParityOdd), .cfgTwoStop(cfgTwoStop), .trigSel(trigSel),
    .enFull(enFull), .enReady(enReady), .enError(enError), .enBreak(enBreak),
    .clrErr(clrErr), .clrBreak(clrBreak), .popEn(popEn), .popData(popData),
    .popParErr(popParErr), .fifoCount(fifoCount), .flagFull(flagFull),
    .flagReady(flagReady), .flagError(flagError), .flagBreak(flagBreak),
    .irqA(irqA), .irqB(irqB)
  );

  always #5 clk = ~clk;
  always @(negedge clk) tick16 <= rstN ? ~tick16 : 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic lineBit(input logic b);
    @(negedge clk) rxLine = b;
    repeat (BITCLK - 1) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit seven, input bit parOn,
                           input bit odd, input bit flip, input bit stopV,
                           input bit two, input bit stop2V);
    logic p;
    int n;
    cfgSevenBits = seven; cfgParityOn = parOn; cfgParityOdd = odd; cfgTwoStop = two;
    n = seven ? 7 : 8;
    p = (seven ? ^d[6:0] : ^d) ^ odd ^ flip;
    lineBit(1'b0);
    for (int i = 0; i < n; i++) lineBit(d[i]);
    if (parOn) lineBit(p);
    lineBit(stopV);
    if (two) lineBit(stop2V);
    @(negedge clk) rxLine = 1'b1;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic good(input logic [7:0] d);
    sendFrame(d, 0, 0, 0, 0, 1, 0, 1);
  endtask

  task automatic popOne(output logic [7:0] d, output logic pe);
    @(negedge clk);
    d = popData; pe = popParErr; popEn = 1'b1;
    @(negedge clk) popEn = 1'b0;
  endtask

  task automatic drain();
    logic [7:0] d;
    logic pe;
    while (fifoCount != 0) popOne(d, pe);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic pe;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 count", fifoCount, 0);
    chk("R12 flags", {flagFull, flagReady, flagError, flagBreak}, 0);
    chk("R12 irq", {irqA, irqB}, 0);

    // R2/R3 vector table
    foreach (VEC[k]) begin
      sendFrame(VEC[k][20:13], VEC[k][12], VEC[k][11], VEC[k][10], VEC[k][9], 1, 0, 1);
      chk("R2 stored", fifoCount, 1);
      popOne(d, pe);
      chk("R2 data", d, VEC[k][8:1]);
      chk("R3 parity flag", pe, VEC[k][0]);
    end

    // R11 head parity error drives error flag, R10 irqB
    enError = 1;
    sendFrame(8'h0F, 0, 1, 0, 1, 1, 0, 1);
    chk("R11 head pe", flagError, 1);
    chk("R10 irqB error", irqB, 1);
    popOne(d, pe);
    chk("R11 after pop", flagError, 0);

    // R4 framing fault, reception continues
    sendFrame(8'h55, 0, 0, 0, 0, 0, 0, 1);
    chk("R4 dropped", fifoCount, 0);
    chk("R4 sticky", flagError, 1);
    good(8'h3C);
    chk("R4 continues", fifoCount, 1);
    chk("R4 data", popData, 8'h3C);
    pulse(clrErr);
    @(negedge clk);
    chk("R4 cleared", flagError, 0);
    enError = 0;
    drain();

    // R5 second stop bit not checked
    sendFrame(8'h96, 0, 0, 0, 0, 1, 1, 0);
    repeat (2 * BITCLK) @(negedge clk);
    chk("R5 stop2 low ok", fifoCount, 1);
    chk("R5 data", popData, 8'h96);
    chk("R5 no error", flagError, 0);
    sendFrame(8'h96, 0, 0, 0, 0, 0, 1, 1);
    chk("R5 stop1 checked", fifoCount, 1);
    chk("R5 stop1 error", flagError, 1);
    pulse(clrErr);
    drain();

    // R1 glitch rejection
    @(negedge clk) rxLine = 1'b0;
    repeat (8) @(negedge clk);
    rxLine = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    chk("R1 glitch", fifoCount, 0);
    good(8'hC3);
    chk("R1 aligned count", fifoCount, 1);
    chk("R1 aligned data", popData, 8'hC3);
    drain();

    // R6 break
    enBreak = 1;
    sendFrame(8'h00, 0, 0, 0, 0, 0, 0, 1);
    repeat (12 * BITCLK) @(negedge clk);
    chk("R6 break flag", flagBreak, 1);
    chk("R10 irqB break", irqB, 1);
    chk("R6 not stored", fifoCount, 0);
    good(8'h11);
    chk("R6 blocked", fifoCount, 0);
    pulse(clrBreak);
    @(negedge clk);
    chk("R6 cleared", flagBreak, 0);
    good(8'h22);
    chk("R6 resumes", fifoCount, 1);
    chk("R6 data", popData, 8'h22);
    enBreak = 0;
    pulse(clrErr);
    drain();

    // R7/R8 fill and trigger levels
    trigSel = 2'd3; enFull = 1;
    for (int i = 1; i <= 17; i++) begin
      good(8'(i));
      if (i == 4) begin
        trigSel = 2'd1; @(negedge clk);
        chk("R8 trig4 full", flagFull, 1);
        trigSel = 2'd2; @(negedge clk);
        chk("R8 trig8 not", flagFull, 0);
        trigSel = 2'd0; @(negedge clk);
        chk("R8 trig1 full", flagFull, 1);
        trigSel = 2'd3; @(negedge clk);
      end
      if (i == 13) chk("R8 13 below 14", flagFull, 0);
      if (i == 14) begin
        chk("R8 14 full", flagFull, 1);
        chk("R10 irqA full", irqA, 1);
      end
    end
    chk("R7 cap", fifoCount, 16);
    popOne(d, pe);
    chk("R7 head kept", d, 1);
    drain();
    enFull = 0;

    // R9 data-ready after idle
    trigSel = 2'd2; enReady = 1;
    good(8'h44);
    repeat (300) @(negedge clk);
    chk("R9 not yet", flagReady, 0);
    chk("R10 irqA quiet", irqA, 0);
    repeat (250) @(negedge clk);
    chk("R9 ready", flagReady, 1);
    chk("R10 irqA ready", irqA, 1);
    enReady = 0;
    @(negedge clk);
    chk("R10 irqA masked", irqA, 0);
    drain();
    chk("R9 empty", flagReady, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule